// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block evaluates four Boolean outputs from six inputs as a sum of products. A first plane of sixteen product terms ANDs chosen input literals together. A second plane ORs chosen product terms into each output. A mode setting decides which plane follows the stored connection bits and which plane uses hard-wired connections. In the shared-term mode both planes are programmable. In the grouped-term mode the AND plane is programmable and each output sums a dedicated group of four terms. In the decoder mode the AND plane is replaced by a full decode of the four low inputs into sixteen minterms, and the OR plane is programmable.

The connection bits, the mode and an output-register enable are loaded through a simple address/data write port. Each write takes effect on the clock edge that accepts it. When the register enable is clear, the outputs follow the inputs combinationally. When it is set, the outputs come from a register that captures the array result on every clock.

Top module: `pla_engine`

## Requirements
- R1: Synchronous active-high reset clears every connection bit, selects the shared-term mode and combinational output. The outputs then read 0 for any input.
- R2: The AND-row word at addresses 0..15 sets term t as follows. Bit 2n connects input n in true form and bit 2n+1 connects it in complemented form. A term with no connections is 1. A term that connects both forms of one input is 0.
- R3: In the shared-term mode, output o is the OR of every term t whose bit t is set in the OR-row word at address 16+o. An output with an empty row is 0.
- R4: In the grouped-term mode, output o is the OR of terms 4o..4o+3. The OR-row words have no effect.
- R5: In the decoder mode, term t is 1 exactly when inputs 3..0 equal t. Inputs 5 and 4 and the AND-row words have no effect. Output o is then bit t of the OR-row word for output o.
- R6: A configuration write changes the outputs only from the clock edge that accepts it. Writes to addresses 21..31 change nothing.
- R7: The control word at address 20 holds the mode in bits 1..0 (0 shared-term, 1 grouped-term, 2 decoder, 3 acts as shared-term) and the output-register enable in bit 2.
- R8: With the register enable set, the outputs show the array result sampled at the previous clock edge. Reset clears the register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 16 | Configuration word data |
| pla_in | input | 6 | Array inputs |
| pla_out | output | 4 | Array outputs |

## Verification
One fixed connection set is loaded, and the same input patterns are applied in every mode. Output differences can then be traced to the mode alone. In shared-term mode the patterns separate a true literal from a complemented one and single-term rows from multi-term rows. In grouped-term mode, patterns that set input 5 with and without input 4 show whether the group wiring is used and the OR rows are ignored. In decoder mode the patterns use addresses whose upper inputs differ, which proves those inputs are ignored. Further directed patterns cover a self-contradicting term, the exact edge where a write takes effect, writes to unused addresses, the one-cycle lag of the registered output, and mode code 3.

// File: rtl/pla_cfg_pkg.sv
package pla_cfg_pkg;

    localparam int N_IN          = 6;
    localparam int N_OUT         = 4;
    localparam int N_TERM        = 16;
    localparam int TERMS_PER_OUT = N_TERM / N_OUT;
    localparam int DEC_BITS      = $clog2(N_TERM);
    localparam int AND_W         = 2 * N_IN;
    localparam int DATA_W        = 16;
    localparam int OR_BASE       = N_TERM;
    localparam int CTRL_ADDR     = N_TERM + N_OUT;
    localparam int ADDR_W        = $clog2(CTRL_ADDR + 1);

    typedef enum logic [1:0] {
        ARR_SHARED  = 2'd0,
        ARR_GROUPED = 2'd1,
        ARR_DECODE  = 2'd2,
        ARR_ALIAS   = 2'd3
    } arr_mode_e;

    typedef logic [AND_W-1:0]  and_row_t;
    typedef logic [N_TERM-1:0] or_row_t;

    typedef struct packed {
        logic      reg_out;
        arr_mode_e mode;
    } ctrl_t;

    function automatic logic term_eval(input and_row_t row, input logic [N_IN-1:0] x);
        logic r;
        r = 1'b1;
        for (int n = 0; n < N_IN; n++) begin
            if (row[2*n] && !x[n])
                r = 1'b0;
            if (row[2*n+1] && x[n])
                r = 1'b0;
        end
        return r;
    endfunction

    function automatic arr_mode_e decode_mode(input logic [1:0] code);
        arr_mode_e m;
        case (code)
            2'd1:    m = ARR_GROUPED;
            2'd2:    m = ARR_DECODE;
            default: m = ARR_SHARED;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output and_row_t          and_cfg [N_TERM],
    output or_row_t           or_cfg  [N_OUT],
    output ctrl_t             ctrl
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_and_row
        always_ff @(posedge clk) begin
            if (rst)
                and_cfg[t] <= '0;
            else if (we && addr == ADDR_W'(t))
                and_cfg[t] <= wdata[AND_W-1:0];
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_or_row
        always_ff @(posedge clk) begin
            if (rst)
                or_cfg[o] <= '0;
            else if (we && addr == ADDR_W'(OR_BASE + o))
                or_cfg[o] <= wdata[N_TERM-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '{reg_out: 1'b0, mode: ARR_SHARED};
        else if (we && addr == ADDR_W'(CTRL_ADDR))
            ctrl <= '{reg_out: wdata[2], mode: decode_mode(wdata[1:0])};
    end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_cfg_pkg::*;
(
    input  arr_mode_e         mode,
    input  logic [N_IN-1:0]   din,
    input  and_row_t          and_cfg [N_TERM],
    output logic [N_TERM-1:0] terms
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        localparam logic [DEC_BITS-1:0] IDX = DEC_BITS'(t);
        logic minterm_hit;
        logic prog_term;
        always_comb begin
            minterm_hit = (din[DEC_BITS-1:0] == IDX);
            prog_term   = term_eval(and_cfg[t], din);
            terms[t]    = (mode == ARR_DECODE) ? minterm_hit : prog_term;
        end
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_cfg_pkg::*;
(
    input  arr_mode_e         mode,
    input  logic [N_TERM-1:0] terms,
    input  or_row_t           or_cfg [N_OUT],
    output logic [N_OUT-1:0]  sums
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        logic group_sum;
        logic prog_sum;
        always_comb begin
            group_sum = |terms[o*TERMS_PER_OUT +: TERMS_PER_OUT];
            prog_sum  = |(terms & or_cfg[o]);
            sums[o]   = (mode == ARR_GROUPED) ? group_sum : prog_sum;
        end
    end

endmodule

// File: rtl/pla_engine.sv
module pla_engine
    import pla_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   pla_in,
    output logic [N_OUT-1:0]  pla_out
);

    and_row_t          and_cfg [N_TERM];
    or_row_t           or_cfg  [N_OUT];
    ctrl_t             ctrl_q;
    logic [N_TERM-1:0] terms;
    logic [N_OUT-1:0]  comb_out;
    logic [N_OUT-1:0]  out_q;

    pla_cfg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .and_cfg (and_cfg),
        .or_cfg  (or_cfg),
        .ctrl    (ctrl_q)
    );

    pla_and_plane u_and (
        .mode    (ctrl_q.mode),
        .din     (pla_in),
        .and_cfg (and_cfg),
        .terms   (terms)
    );

    pla_or_plane u_or (
        .mode    (ctrl_q.mode),
        .terms   (terms),
        .or_cfg  (or_cfg),
        .sums    (comb_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= comb_out;
    end

    assign pla_out = ctrl_q.reg_out ? out_q : comb_out;

endmodule

// File: rtl/pla_engine_chk.sv
module pla_engine_chk
    import pla_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [N_OUT-1:0]  pla_out,
    input ctrl_t             ctrl_q,
    input logic [N_TERM-1:0] terms,
    input logic [N_OUT-1:0]  comb_out,
    input and_row_t          and_row0
);

    AST_RESET_CLEARS_OUT: assert property (@(posedge clk)
        rst |=> (pla_out == '0)); // R1

    AST_EMPTY_TERM_TRUE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode != ARR_DECODE && and_row0 == '0) |-> terms[0]); // R2

    AST_GROUP_SUM_OUT0: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == ARR_GROUPED) |-> (comb_out[0] == |terms[TERMS_PER_OUT-1:0])); // R4

    AST_DECODE_ONE_TERM: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == ARR_DECODE) |-> ($countones(terms) == 1)); // R5

    AST_UNUSED_ADDR_NOP: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr > ADDR_W'(CTRL_ADDR)) |=> $stable(ctrl_q)); // R6

    AST_NO_ALIAS_MODE: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.mode != ARR_ALIAS); // R7

    AST_REG_LAGS_ONE: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.reg_out |-> (pla_out == $past(comb_out))); // R8

endmodule

bind pla_engine pla_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .pla_out  (pla_out),
    .ctrl_q   (ctrl_q),
    .terms    (terms),
    .comb_out (comb_out),
    .and_row0 (and_cfg[0])
);

// File: tb/test_pla_engine.sv
module test_pla_engine;
    import pla_cfg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 15;

    // vector: {mode[1:0], input[5:0], expected[3:0]}
    localparam logic [11:0] VECS [N_VEC] = '{
        {2'd0, 6'b000000, 4'b0101},
        {2'd0, 6'b000010, 4'b0100},
        {2'd0, 6'b001110, 4'b0110},
        {2'd0, 6'b000011, 4'b0101},
        {2'd1, 6'b000010, 4'b1000},
        {2'd1, 6'b100010, 4'b1001},
        {2'd1, 6'b010011, 4'b1111},
        {2'd1, 6'b110010, 4'b1010},
        {2'd2, 6'b000000, 4'b0001},
        {2'd2, 6'b110001, 4'b0001},
        {2'd2, 6'b000010, 4'b0010},
        {2'd2, 6'b001111, 4'b0100},
        {2'd2, 6'b000100, 4'b0100},
        {2'd2, 6'b000111, 4'b0000},
        {2'd3, 6'b000000, 4'b0101}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [N_IN-1:0]   pla_in = '0;
    logic [N_OUT-1:0]  pla_out;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_engine i_pla_engine (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pla_in    (pla_in),
        .pla_out   (pla_out)
    );

    task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b (in=%b)", req, act, exp, pla_in);
        end
    endtask

    task automatic cfg_write(input int addr, input logic [DATA_W-1:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = ADDR_W'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, empty OR rows give 0
        pla_in = 6'b000000; #1; check("R1", pla_out, 4'b0000);
        pla_in = 6'b111111; #1; check("R1", pla_out, 4'b0000);

        // AND rows (R2 encoding: bit 2n true, 2n+1 complement)
        cfg_write(0,  16'h0001);  // in0
        cfg_write(1,  16'h0008);  // ~in1
        cfg_write(2,  16'h0050);  // in2 & in3
        cfg_write(3,  16'h0600);  // ~in4 & in5
        cfg_write(4,  16'h0003);  // in0 & ~in0
        cfg_write(5,  16'h0100);  // in4
        cfg_write(6,  16'h0003);
        cfg_write(7,  16'h0003);
        cfg_write(8,  16'h0005);  // in0 & in1
        cfg_write(9,  16'h0003);
        cfg_write(10, 16'h0003);
        cfg_write(11, 16'h0003);
        // OR rows
        cfg_write(16, 16'h0003);
        cfg_write(17, 16'h0004);
        cfg_write(18, 16'h8010);
        cfg_write(19, 16'h0000);

        for (int v = 0; v < N_VEC; v++) begin
            cfg_write(CTRL_ADDR, {14'd0, VECS[v][11:10]});
            pla_in = VECS[v][9:4];
            #1;
            check(mode_req(VECS[v][11:10]), pla_out, VECS[v][3:0]);
        end

        // R2: contradictory term is 0, unconnected term is 1
        cfg_write(CTRL_ADDR, 16'h0000);
        cfg_write(19, 16'h0010);
        pla_in = 6'b000000; #1; check("R2", pla_out[3], 1'b0);
        pla_in = 6'b000001; #1; check("R2", pla_out[3], 1'b0);
        cfg_write(19, 16'h8000);
        pla_in = 6'b101010; #1; check("R2", pla_out[3], 1'b1);

        // R6: write takes effect at the accepting edge
        cfg_write(19, 16'h0010);
        pla_in = 6'b010000;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(19); cfg_wdata = 16'h0020;
        #1; check("R6", pla_out[3], 1'b0);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        check("R6", pla_out[3], 1'b1);

        // R6: unused addresses ignored
        cfg_write(21, 16'hFFFF);
        cfg_write(31, 16'hFFFF);
        pla_in = 6'b000000; #1; check("R6", pla_out, 4'b0101);
        pla_in = 6'b010010; #1; check("R6", pla_out, 4'b1100);

        // R8: registered output lags by one edge
        pla_in = 6'b000000;
        cfg_write(CTRL_ADDR, 16'h0004);
        @(negedge clk);
        check("R8", pla_out, 4'b0101);
        pla_in = 6'b010010; #1;
        check("R8", pla_out, 4'b0101);
        @(posedge clk); #1;
        check("R8", pla_out, 4'b1100);

        // R1/R8: reset clears register and configuration
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1; check("R1", pla_out, 4'b0000);
        @(negedge clk); check("R8", pla_out, 4'b0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule